// File: doc/BRIEF.md
# Four-Channel DMA Register File

This block is the processor-side register bank of a four-channel DMA controller. A processor reaches it through an 8-bit port bus: a 4-bit port offset, a write byte, and single-cycle read and write strobes. For each channel the block keeps a 16-bit base address, a 16-bit base count, working copies of both (the current address and current count), a mode byte and an 8-bit page value that gives memory address bits 23:16. A 4-bit mask gates each channel, and a status byte collects terminal-count events that the transfer engine reports.

The 16-bit registers sit behind 8-bit ports. One shared byte-pointer flag decides whether an access reaches the low or the high byte, and every address or count access, read or write, flips it. Several offsets hold no data at all: a write to them is a command that clears the pointer, clears or sets the mask, or does both. A separate transfer engine reads all channel registers and mask bits from the block's outputs. Page values are loaded through their own strobe. All outputs are registered, and read data appears one cycle after the read strobe.

Top module: `xfer_ctl_regs`

## Requirements
- R1: After a synchronous reset all four mask bits are 1, the byte pointer is clear (low byte next), every channel register, page and mode is 0, and read data is 0.
- R2: A write to offset 2n loads channel n's base address and a write to offset 2n+1 loads its base count. The low byte is loaded when the pointer is clear and the high byte when it is set, and each such write flips the pointer.
- R3: A high-byte write to a base address or base count copies the whole new 16-bit base value into the matching current register in the same cycle. A low-byte write leaves the current register unchanged.
- R4: A read of offset 2n (address) or 2n+1 (count) returns the low byte (pointer clear) or high byte (pointer set) of the current register on the read data one cycle after the strobe, and flips the pointer.
- R5: A write to offset 0xB stores the whole data byte as the mode of the channel named by data bits 1:0.
- R6: A write to offset 0xA picks the channel from data bits 1:0. Data bit 2 = 1 sets that channel's mask bit, and data bit 2 = 0 clears it. The other mask bits keep their values.
- R7: A write to offset 0xF loads data bits 3:0 into mask bits 3:0 (bit n masks channel n).
- R8: Any write to offset 0xC clears the byte pointer. Any write to offset 0xE clears all four mask bits.
- R9: Any write to offset 0xD clears the byte pointer and sets all four mask bits.
- R10: A read of offset 0x8 returns {4'b0000, terminal-count flags 3:0} and clears the flags. A terminal-count pulse that arrives in the same cycle as that read is kept for the next read.
- R11: A page strobe loads the data byte into the page of the channel named by offset bits 1:0, and the byte pointer is unchanged.
- R12: When read and write strobes are both high, only the write takes effect and the read data holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Port offset |
| bus_wdata | input | 8 | Write data byte |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| page_wr | input | 1 | Page load strobe; channel from bus_addr[1:0], data from bus_wdata |
| tc_hit | input | 4 | Terminal-count pulses from the transfer engine, one bit per channel |
| bus_rdata | output | 8 | Registered read data |
| base_addr_o | output | 64 | Base address of each channel, channel n in bits 16n+15:16n |
| cur_addr_o | output | 64 | Current address of each channel |
| base_cnt_o | output | 64 | Base count of each channel |
| cur_cnt_o | output | 64 | Current count of each channel |
| mode_o | output | 32 | Mode byte of each channel, channel n in bits 8n+7:8n |
| page_o | output | 32 | Page byte of each channel |
| chan_mask_o | output | 4 | Mask bits, 1 = channel masked |

## Verification
A byte pointer that is out of phase does not show in any single register. It shows at the next 16-bit access, where a byte lands in the wrong half of a base register or a read returns the wrong half, and every access after that stays swapped until a pointer clear or master clear. For that reason the tests follow each command strobe with a byte write and read the register back. A wrong mask or mode shows on the outputs one cycle after the write. A wrong status flag shows only at the next status read, so the tests read status twice to see both the returned value and the clear.

// File: rtl/xfer_regs_pkg.sv
package xfer_regs_pkg;
  localparam int OFS_W = 4;
  localparam logic [OFS_W-1:0] OFS_STATUS  = 4'h8;
  localparam logic [OFS_W-1:0] OFS_MASK1   = 4'hA;
  localparam logic [OFS_W-1:0] OFS_MODE    = 4'hB;
  localparam logic [OFS_W-1:0] OFS_PTRCLR  = 4'hC;
  localparam logic [OFS_W-1:0] OFS_MCLR    = 4'hD;
  localparam logic [OFS_W-1:0] OFS_MASKCLR = 4'hE;
  localparam logic [OFS_W-1:0] OFS_MASKALL = 4'hF;

  // channel ports occupy the lower half of the offset space
  function automatic logic is_chan_port(input logic [OFS_W-1:0] a);
    return ~a[OFS_W-1];
  endfunction
endpackage

// File: rtl/xfer_byteptr.sv
module xfer_byteptr (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic clr,
  output logic ptr_o
);
  always_ff @(posedge clk) begin
    if (rst)       ptr_o <= 1'b0;
    else if (clr)  ptr_o <= 1'b0;
    else if (step) ptr_o <= ~ptr_o;
  end
endmodule

// File: rtl/xfer_chan_regs.sv
module xfer_chan_regs #(
  parameter int BW  = 8,
  parameter int IDX = 0,
  parameter int CHW = 2,
  parameter int AW  = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   addr,
  input  logic [BW-1:0]   wdata,
  input  logic            wr,
  input  logic            ptr,
  input  logic            page_wr,
  output logic [2*BW-1:0] base_addr_o,
  output logic [2*BW-1:0] cur_addr_o,
  output logic [2*BW-1:0] base_cnt_o,
  output logic [2*BW-1:0] cur_cnt_o,
  output logic [BW-1:0]   mode_o,
  output logic [BW-1:0]   page_o
);
  import xfer_regs_pkg::*;
  localparam logic [AW-1:0]  A_OFS  = AW'(2*IDX);
  localparam logic [AW-1:0]  C_OFS  = AW'(2*IDX+1);
  localparam logic [CHW-1:0] MY_SEL = CHW'(IDX);

  logic wr_a, wr_c, wr_m, wr_p;
  always_comb begin
    wr_a = wr && (addr == A_OFS);
    wr_c = wr && (addr == C_OFS);
    wr_m = wr && (addr == OFS_MODE) && (wdata[CHW-1:0] == MY_SEL);
    wr_p = page_wr && (addr[CHW-1:0] == MY_SEL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr_o <= '0;
      cur_addr_o  <= '0;
    end else if (wr_a) begin
      if (ptr) begin
        base_addr_o[2*BW-1:BW] <= wdata;
        cur_addr_o             <= {wdata, base_addr_o[BW-1:0]};
      end else begin
        base_addr_o[BW-1:0] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_cnt_o <= '0;
      cur_cnt_o  <= '0;
    end else if (wr_c) begin
      if (ptr) begin
        base_cnt_o[2*BW-1:BW] <= wdata;
        cur_cnt_o             <= {wdata, base_cnt_o[BW-1:0]};
      end else begin
        base_cnt_o[BW-1:0] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       mode_o <= '0;
    else if (wr_m) mode_o <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)       page_o <= '0;
    else if (wr_p) page_o <= wdata;
  end
endmodule

// File: rtl/xfer_mask_stat.sv
module xfer_mask_stat #(
  parameter int NCH = 4,
  parameter int CHW = 2,
  parameter int AW  = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr,
  input  logic [AW-1:0]  addr,
  input  logic [NCH-1:0] wd,
  input  logic           stat_rd,
  input  logic [NCH-1:0] tc_hit,
  output logic [NCH-1:0] mask_o,
  output logic [NCH-1:0] tc_o
);
  import xfer_regs_pkg::*;
  logic [NCH-1:0] mask_d;

  always_comb begin
    mask_d = mask_o;
    if (wr) begin
      unique case (addr)
        OFS_MASK1:   mask_d[wd[CHW-1:0]] = wd[CHW];
        OFS_MASKALL: mask_d = wd;
        OFS_MASKCLR: mask_d = '0;
        OFS_MCLR:    mask_d = '1;
        default:     mask_d = mask_o;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mask_o <= '1;
    else     mask_o <= mask_d;
  end

  // a pulse arriving with the clearing read is kept
  always_ff @(posedge clk) begin
    if (rst) tc_o <= '0;
    else     tc_o <= (stat_rd ? '0 : tc_o) | tc_hit;
  end
endmodule

// File: rtl/xfer_ctl_regs.sv
module xfer_ctl_regs #(
  parameter int NCH = 4,
  parameter int BW  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [3:0]         bus_addr,
  input  logic [BW-1:0]      bus_wdata,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic               page_wr,
  input  logic [NCH-1:0]     tc_hit,
  output logic [BW-1:0]      bus_rdata,
  output logic [NCH*2*BW-1:0] base_addr_o,
  output logic [NCH*2*BW-1:0] cur_addr_o,
  output logic [NCH*2*BW-1:0] base_cnt_o,
  output logic [NCH*2*BW-1:0] cur_cnt_o,
  output logic [NCH*BW-1:0]  mode_o,
  output logic [NCH*BW-1:0]  page_o,
  output logic [NCH-1:0]     chan_mask_o
);
  import xfer_regs_pkg::*;
  localparam int RW  = 2 * BW;
  localparam int CHW = $clog2(NCH);
  localparam int AW  = OFS_W;

  logic           ptr_q;
  logic           rd_ok;
  logic           stat_rd;
  logic           ptr_step;
  logic           ptr_clr;
  logic [NCH-1:0] stat_tc;

  always_comb begin
    rd_ok    = bus_rd && !bus_wr;
    stat_rd  = rd_ok && (bus_addr == OFS_STATUS);
    ptr_step = (bus_wr || bus_rd) && is_chan_port(bus_addr);
    ptr_clr  = bus_wr && ((bus_addr == OFS_PTRCLR) || (bus_addr == OFS_MCLR));
  end

  xfer_byteptr u_ptr (
    .clk(clk), .rst(rst), .step(ptr_step), .clr(ptr_clr), .ptr_o(ptr_q)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    xfer_chan_regs #(.BW(BW), .IDX(c), .CHW(CHW), .AW(AW)) u_ch (
      .clk        (clk),
      .rst        (rst),
      .addr       (bus_addr),
      .wdata      (bus_wdata),
      .wr         (bus_wr),
      .ptr        (ptr_q),
      .page_wr    (page_wr),
      .base_addr_o(base_addr_o[c*RW +: RW]),
      .cur_addr_o (cur_addr_o[c*RW +: RW]),
      .base_cnt_o (base_cnt_o[c*RW +: RW]),
      .cur_cnt_o  (cur_cnt_o[c*RW +: RW]),
      .mode_o     (mode_o[c*BW +: BW]),
      .page_o     (page_o[c*BW +: BW])
    );
  end

  xfer_mask_stat #(.NCH(NCH), .CHW(CHW), .AW(AW)) u_ms (
    .clk    (clk),
    .rst    (rst),
    .wr     (bus_wr),
    .addr   (bus_addr),
    .wd     (bus_wdata[NCH-1:0]),
    .stat_rd(stat_rd),
    .tc_hit (tc_hit),
    .mask_o (chan_mask_o),
    .tc_o   (stat_tc)
  );

  // read path: pick the current register word, then the byte
  logic [CHW-1:0] rsel;
  logic [RW-1:0]  rword;
  logic [BW-1:0]  rbyte;

  always_comb begin
    rsel  = bus_addr[CHW:1];
    rword = bus_addr[0] ? cur_cnt_o[rsel*RW +: RW] : cur_addr_o[rsel*RW +: RW];
    if (is_chan_port(bus_addr))
      rbyte = ptr_q ? rword[RW-1:BW] : rword[BW-1:0];
    else if (bus_addr == OFS_STATUS)
      rbyte = BW'(stat_tc);
    else
      rbyte = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= '0;
    else if (rd_ok) bus_rdata <= rbyte;
  end
endmodule

// File: rtl/xfer_ctl_regs_chk.sv
module xfer_ctl_regs_chk #(
  parameter int NCH = 4,
  parameter int BW  = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [3:0]      bus_addr,
  input logic [BW-1:0]   bus_wdata,
  input logic            bus_wr,
  input logic            bus_rd,
  input logic            page_wr,
  input logic [NCH-1:0]  tc_hit,
  input logic [BW-1:0]   bus_rdata,
  input logic [NCH-1:0]  mask,
  input logic            ptr,
  input logic [NCH-1:0]  tc,
  input logic [2*BW-1:0] base0,
  input logic [2*BW-1:0] cur0
);
  logic chan_acc, stat_rd;
  always_comb begin
    chan_acc = (bus_wr || bus_rd) && !bus_addr[3];
    stat_rd  = bus_rd && !bus_wr && (bus_addr == 4'h8);
  end

  p_ptr_flip_r2: assert property (@(posedge clk) disable iff (rst)
    chan_acc |=> ptr == !$past(ptr));

  p_hi_copy_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 4'h0 && ptr) |=> cur0 == base0);

  p_lo_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 4'h0 && !ptr) |=> $stable(cur0));

  p_all_mask_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 4'hF) |=> mask == $past(bus_wdata[NCH-1:0]));

  p_mask_clr_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 4'hE) |=> mask == '0);

  p_ptr_clr_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 4'hC) |=> !ptr);

  p_mclr_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 4'hD) |=> (mask == '1) && !ptr);

  p_stat_read_r10: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && tc_hit == '0) |=> (bus_rdata == BW'($past(tc))) && (tc == '0));

  p_page_ptr_r11: assert property (@(posedge clk) disable iff (rst)
    (page_wr && !bus_wr && !bus_rd) |=> $stable(ptr));

  p_rd_wr_r12: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_rd) |=> $stable(bus_rdata));
endmodule

bind xfer_ctl_regs xfer_ctl_regs_chk #(.NCH(NCH), .BW(BW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .page_wr  (page_wr),
  .tc_hit   (tc_hit),
  .bus_rdata(bus_rdata),
  .mask     (chan_mask_o),
  .ptr      (ptr_q),
  .tc       (stat_tc),
  .base0    (base_addr_o[RW-1:0]),
  .cur0     (cur_addr_o[RW-1:0])
);

// File: tb/sim_xfer_ctl_regs.sv
`timescale 1ns/1ps
module sim_xfer_ctl_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, page_wr = 1'b0;
  logic [3:0]  tc_hit = '0;
  logic [7:0]  bus_rdata;
  logic [63:0] base_addr_o, cur_addr_o, base_cnt_o, cur_cnt_o;
  logic [31:0] mode_o, page_o;
  logic [3:0]  chan_mask_o;

  int n_chk = 0, n_bad = 0;
  logic [7:0] rv;

  always #10 clk = ~clk;

  xfer_ctl_regs u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic t_reset;
    chk("R1 mask", chan_mask_o, 32'hF);
    chk("R1 rdata", bus_rdata, 0);
    chk("R1 base", base_addr_o[31:0], 0);
    chk("R1 mode", mode_o, 0);
    wr(4'h0, 8'hAB);  // pointer clear after reset -> low byte
    chk("R1 ptr", base_addr_o[15:0], 32'h00AB);
    wr(4'hC, 8'h00);
  endtask

  task automatic t_program;
    wr(4'h2, 8'h34);
    chk("R2 low byte", base_addr_o[31:16], 32'h0034);
    chk("R3 low keeps cur", cur_addr_o[31:16], 0);
    wr(4'h2, 8'h12);
    chk("R2 high byte", base_addr_o[31:16], 32'h1234);
    chk("R3 copy cur", cur_addr_o[31:16], 32'h1234);
    wr(4'h5, 8'hCD);
    wr(4'h5, 8'hAB);
    chk("R2 count", base_cnt_o[47:32], 32'hABCD);
    chk("R3 count cur", cur_cnt_o[47:32], 32'hABCD);
  endtask

  task automatic t_readback;
    rd(4'h2, rv); chk("R4 addr lo", rv, 32'h34);
    rd(4'h2, rv); chk("R4 addr hi", rv, 32'h12);
    rd(4'h5, rv); chk("R4 cnt lo", rv, 32'hCD);
    rd(4'h5, rv); chk("R4 cnt hi", rv, 32'hAB);
  endtask

  task automatic t_ptr_cmds;
    wr(4'h0, 8'h11);
    wr(4'hC, 8'h5A);
    wr(4'h0, 8'h77);
    chk("R8 ptr clear", base_addr_o[15:0], 32'h0077);
    wr(4'hC, 8'h00);
    wr(4'h0, 8'h22);
    wr(4'hD, 8'h00);
    chk("R9 mask set", chan_mask_o, 32'hF);
    wr(4'h0, 8'h66);
    chk("R9 ptr clear", base_addr_o[15:0], 32'h0066);
    wr(4'hC, 8'h00);
  endtask

  task automatic t_mode;
    wr(4'hB, 8'h4A);
    chk("R5 mode ch2", mode_o[23:16], 32'h4A);
    chk("R5 others", {mode_o[31:24], mode_o[15:0]}, 0);
    wr(4'hB, 8'h97);
    chk("R5 mode ch3", mode_o[31:24], 32'h97);
  endtask

  task automatic t_mask;
    wr(4'hE, 8'h00); chk("R8 mask clr", chan_mask_o, 0);
    wr(4'hA, 8'h05); chk("R6 set bit1", chan_mask_o, 32'h2);
    wr(4'hA, 8'h07); chk("R6 set bit3", chan_mask_o, 32'hA);
    wr(4'hA, 8'h01); chk("R6 clr bit1", chan_mask_o, 32'h8);
    wr(4'hF, 8'hF9); chk("R7 all mask", chan_mask_o, 32'h9);
    wr(4'hD, 8'h00); chk("R9 mclr", chan_mask_o, 32'hF);
  endtask

  task automatic t_status;
    @(negedge clk); tc_hit = 4'b0101;
    @(negedge clk); tc_hit = 4'b0000;
    rd(4'h8, rv); chk("R10 status", rv, 32'h05);
    rd(4'h8, rv); chk("R10 cleared", rv, 0);
    @(negedge clk); bus_addr = 4'h8; bus_rd = 1'b1; tc_hit = 4'b1000;
    @(negedge clk); bus_rd = 1'b0; tc_hit = 4'b0000; rv = bus_rdata;
    chk("R10 read with pulse", rv, 0);
    rd(4'h8, rv); chk("R10 pulse kept", rv, 32'h08);
  endtask

  task automatic t_page;
    wr(4'h6, 8'h10);
    @(negedge clk); bus_addr = 4'h3; bus_wdata = 8'h9A; page_wr = 1'b1;
    @(negedge clk); page_wr = 1'b0;
    chk("R11 page ch3", page_o[31:24], 32'h9A);
    chk("R11 other pages", page_o[23:0], 0);
    wr(4'h6, 8'h20);
    chk("R11 ptr kept", base_addr_o[63:48], 32'h2010);
  endtask

  task automatic t_both;
    rd(4'h2, rv);  // pointer now set, rdata = 0x34
    @(negedge clk); bus_addr = 4'h2; bus_wdata = 8'hEE; bus_wr = 1'b1; bus_rd = 1'b1;
    @(negedge clk); bus_wr = 1'b0; bus_rd = 1'b0;
    chk("R12 rdata held", bus_rdata, 32'h34);
    chk("R12 write done", base_addr_o[31:16], 32'hEE34);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_program();
    t_readback();
    t_ptr_cmds();
    t_mode();
    t_mask();
    t_status();
    t_page();
    t_both();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule